// File: doc/BRIEF.md
# Write-Through Snooping Cache Controller

This controller sits between one processor and a shared memory bus. It keeps a small direct-mapped cache of single-word lines. Each line holds only a valid flag, a tag and a data word. Reads that hit are served from the cache. Reads that miss fetch the word over the bus, and the processor waits until the fill returns. Every processor write goes straight to memory as a bus write, whether or not the word is cached. A write that misses does not allocate a line.

Each bus write also tells the peer caches what happened. A mode input, sampled when the write is accepted, selects one of two write transactions. In update mode the transaction carries the new data, and peers patch their copy. In invalidate mode the transaction asks peers to drop their copy. The controller also watches the writes issued by its peers. A peer update overwrites the matching line, and a peer invalidate clears it. Traffic that carries the controller's own requester ID is ignored, and so are bus reads. Lines carry no dirty state, so an eviction never causes bus traffic.

Top module: `wtc_ctrl`

## Requirements
- R1: After reset every line is invalid, `cpu_ready` and `bus_req_valid` are low, and the first read of any address misses.
- R2: A read that hits issues no bus request. `cpu_ready` pulses in the cycle after acceptance, with the cached word on `cpu_rdata`.
- R3: A read that misses raises one bus request of type 1 (read) for `cpu_addr`. The request is held until `bus_ack`. `cpu_ready` pulses in the cycle after the ack, with `bus_rd_data` on `cpu_rdata`, and the line is then installed valid.
- R4: Every write, hit or miss, raises a bus request carrying `cpu_addr` and `cpu_wdata` with requester ID `MY_ID`. The request is held until `bus_ack`, and `cpu_ready` pulses in the cycle after the ack.
- R5: A write accepted with `mode_inv`=0 uses type 2 (write with update). With `mode_inv`=1 it uses type 3 (write with invalidate).
- R6: A write that hits replaces the cached word. A write that misses leaves the cache unchanged, so a later read of that address misses.
- R7: A snoop of type 2 from another requester overwrites the data of a valid line whose index and tag match. A snoop whose tag does not match leaves the line unchanged.
- R8: A snoop of type 3 from another requester invalidates a valid matching line.
- R9: A snoop whose `snp_id` equals `MY_ID` has no effect on the cache.
- R10: A snoop of type 1 (read) has no effect on the cache.
- R11: When a snoop to a line arrives in the same cycle as the fill of that line, the snoop is applied to the freshly filled line. The processor still receives the fill data.
- R12: `cpu_ready` is a one-cycle pulse. `bus_req_valid` is only raised while `cpu_req` is held. An address is split into a line index (the low `log2(LINES)` bits) and a tag (the remaining bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_inv | input | 1 | Peer policy for writes: 0 update, 1 invalidate |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 for a write, 0 for a read |
| cpu_addr | input | ADDR_W | Word address, held during the request |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| bus_req_valid | output | 1 | Bus transaction pending |
| bus_req_type | output | 2 | 1 read, 2 write with update, 3 write with invalidate |
| bus_req_id | output | ID_W | Requester ID (`MY_ID`) |
| bus_req_addr | output | ADDR_W | Transaction address |
| bus_req_data | output | DATA_W | Write data |
| bus_ack | input | 1 | Memory completed the pending transaction |
| bus_rd_data | input | DATA_W | Fill data, valid with `bus_ack` on a read |
| snp_valid | input | 1 | A bus transaction is visible to snoop |
| snp_type | input | 2 | Type of the snooped transaction |
| snp_id | input | ID_W | Requester ID of the snooped transaction |
| snp_addr | input | ADDR_W | Address of the snooped transaction |
| snp_data | input | DATA_W | Data of the snooped transaction |

## Verification
A fill and a peer snoop can land on the same line in one cycle. This happens when memory acks a read miss while a peer write to the same address is visible on the snoop port. The bench provokes it during a read miss by driving a snoop of type 2 or type 3 in the ack cycle. It first checks that the processor receives the fill word. A follow-up read then shows the final line state: a hit returning the snooped data in update mode, or a miss in invalidate mode. Constrained random traffic mixes reads, writes and snoops, including foreign, own-ID and read-type snoops, and checks every read against a bench memory model.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    BT_NONE = 2'd0,
    BT_READ = 2'd1,
    BT_WUPD = 2'd2,
    BT_WINV = 2'd3
  } bus_op_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RD   = 2'd1,
    S_WR   = 2'd2,
    S_DONE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
  parameter int LINES  = 8,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              snp_en,
  input  logic              snp_inv,
  input  logic [IDX_W-1:0]  snp_idx,
  input  logic [TAG_W-1:0]  snp_tag,
  input  logic [DATA_W-1:0] snp_data
);
  logic              v_q [LINES];
  logic [TAG_W-1:0]  t_q [LINES];
  logic [DATA_W-1:0] d_q [LINES];

  assign rd_valid = v_q[rd_idx];
  assign rd_tag   = t_q[rd_idx];
  assign rd_data  = d_q[rd_idx];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic              v_n;
    logic [TAG_W-1:0]  t_n;
    logic [DATA_W-1:0] d_n;
    logic              snp_hit;

    // local write first, then the snoop sees the updated line
    always_comb begin
      v_n = v_q[i];
      t_n = t_q[i];
      d_n = d_q[i];
      if (wr_en && wr_idx == IDX_W'(i)) begin
        v_n = 1'b1;
        t_n = wr_tag;
        d_n = wr_data;
      end
      snp_hit = snp_en && (snp_idx == IDX_W'(i)) && v_n && (t_n == snp_tag);
      if (snp_hit) begin
        if (snp_inv) v_n = 1'b0;
        else         d_n = snp_data;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q[i] <= 1'b0;
        t_q[i] <= '0;
        d_q[i] <= '0;
      end else begin
        v_q[i] <= v_n;
        t_q[i] <= t_n;
        d_q[i] <= d_n;
      end
    end
  end
endmodule

// File: rtl/wtc_seq.sv
module wtc_seq
  import wtc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              mode_inv,
  input  logic              lk_hit,
  input  logic [DATA_W-1:0] lk_data,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rd_data,
  output logic              ev_accept_wr,
  output logic              ev_fill,
  output logic              bus_req_valid,
  output bus_op_e           bus_req_type,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata
);
  seq_state_e        st_q;
  logic              inv_q;
  logic [DATA_W-1:0] rdata_q;

  assign ev_accept_wr  = (st_q == S_IDLE) && cpu_req && cpu_we;
  assign ev_fill       = (st_q == S_RD) && bus_ack;
  assign bus_req_valid = (st_q == S_RD) || (st_q == S_WR);
  assign cpu_ready     = (st_q == S_DONE);
  assign cpu_rdata     = rdata_q;

  always_comb begin
    bus_req_type = BT_NONE;
    if (st_q == S_RD)      bus_req_type = BT_READ;
    else if (st_q == S_WR) bus_req_type = inv_q ? BT_WINV : BT_WUPD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      inv_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (cpu_req) begin
          if (cpu_we) begin
            inv_q <= mode_inv;
            st_q  <= S_WR;
          end else if (lk_hit) begin
            rdata_q <= lk_data;
            st_q    <= S_DONE;
          end else begin
            st_q <= S_RD;
          end
        end
        S_RD: if (bus_ack) begin
          rdata_q <= bus_rd_data;
          st_q    <= S_DONE;
        end
        S_WR:    if (bus_ack) st_q <= S_DONE;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_inv,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_type,
  output logic [ID_W-1:0]   bus_req_id,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_data,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rd_data,
  input  logic              snp_valid,
  input  logic [1:0]        snp_type,
  input  logic [ID_W-1:0]   snp_id,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  function automatic logic [IDX_W-1:0] addr_idx(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  logic              lk_valid;
  logic [TAG_W-1:0]  lk_tag;
  logic [DATA_W-1:0] lk_data;
  logic              lk_hit;
  logic              ev_accept_wr;
  logic              ev_fill;
  logic              ev_wr_hit;
  logic              line_wr_en;
  logic [DATA_W-1:0] line_wr_data;
  logic              snp_foreign;
  logic              snp_en;
  logic              snp_inv;
  bus_op_e           req_type;

  assign lk_hit       = lk_valid && (lk_tag == addr_tag(cpu_addr));
  assign ev_wr_hit    = ev_accept_wr && lk_hit;
  assign line_wr_en   = ev_fill || ev_wr_hit;
  assign line_wr_data = ev_fill ? bus_rd_data : cpu_wdata;

  assign snp_foreign = snp_valid && (snp_id != ID_W'(MY_ID));
  assign snp_en      = snp_foreign && (snp_type == BT_WUPD || snp_type == BT_WINV);
  assign snp_inv     = (snp_type == BT_WINV);

  assign bus_req_type = req_type;
  assign bus_req_id   = ID_W'(MY_ID);
  assign bus_req_addr = cpu_addr;
  assign bus_req_data = cpu_wdata;

  wtc_line_store #(
    .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (addr_idx(cpu_addr)),
    .rd_valid (lk_valid),
    .rd_tag   (lk_tag),
    .rd_data  (lk_data),
    .wr_en    (line_wr_en),
    .wr_idx   (addr_idx(cpu_addr)),
    .wr_tag   (addr_tag(cpu_addr)),
    .wr_data  (line_wr_data),
    .snp_en   (snp_en),
    .snp_inv  (snp_inv),
    .snp_idx  (addr_idx(snp_addr)),
    .snp_tag  (addr_tag(snp_addr)),
    .snp_data (snp_data)
  );

  wtc_seq #(.DATA_W(DATA_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req       (cpu_req),
    .cpu_we        (cpu_we),
    .mode_inv      (mode_inv),
    .lk_hit        (lk_hit),
    .lk_data       (lk_data),
    .bus_ack       (bus_ack),
    .bus_rd_data   (bus_rd_data),
    .ev_accept_wr  (ev_accept_wr),
    .ev_fill       (ev_fill),
    .bus_req_valid (bus_req_valid),
    .bus_req_type  (req_type),
    .cpu_ready     (cpu_ready),
    .cpu_rdata     (cpu_rdata)
  );
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
  parameter int ID_W  = 2,
  parameter int MY_ID = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cpu_req,
  input logic            cpu_we,
  input logic            cpu_ready,
  input logic            bus_req_valid,
  input logic [1:0]      bus_req_type,
  input logic [ID_W-1:0] bus_req_id,
  input logic            bus_ack,
  input logic            ev_fill
);
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready); // R12
  AST_REQ_NEEDS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> cpu_req); // R12
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_ack |=> bus_req_valid && $stable(bus_req_type)); // R4
  AST_ACK_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && bus_ack |=> cpu_ready); // R3
  AST_TYPE_MATCHES_OP: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> ((bus_req_type == 2'd1) == !cpu_we) && bus_req_type != 2'd0); // R5
  AST_OWN_ID: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> bus_req_id == ID_W'(MY_ID)); // R4
  AST_FILL_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill |-> !cpu_we && bus_req_type == 2'd1); // R6
endmodule

bind wtc_ctrl wtc_checker #(.ID_W(ID_W), .MY_ID(MY_ID)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_req       (cpu_req),
  .cpu_we        (cpu_we),
  .cpu_ready     (cpu_ready),
  .bus_req_valid (bus_req_valid),
  .bus_req_type  (bus_req_type),
  .bus_req_id    (bus_req_id),
  .bus_ack       (bus_ack),
  .ev_fill       (ev_fill)
);

// File: tb/wtc_ctrl_bench.sv
`timescale 1ns/1ps
module wtc_ctrl_bench;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int LINES  = 8;
  localparam int ID_W   = 2;
  localparam int MY_ID  = 1;
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int MEMSZ  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_inv = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic [DATA_W-1:0] cpu_rdata;
  logic cpu_ready, bus_req_valid;
  logic [1:0] bus_req_type;
  logic [ID_W-1:0] bus_req_id;
  logic [ADDR_W-1:0] bus_req_addr;
  logic [DATA_W-1:0] bus_req_data;
  logic bus_ack = 1'b0;
  logic [DATA_W-1:0] bus_rd_data = '0;
  logic snp_valid = 1'b0;
  logic [1:0] snp_type = '0;
  logic [ID_W-1:0] snp_id = '0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic [DATA_W-1:0] snp_data = '0;

  always #2 clk = ~clk;

  wtc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .ID_W(ID_W), .MY_ID(MY_ID)) u_wtc_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_inv(mode_inv),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .bus_req_valid(bus_req_valid), .bus_req_type(bus_req_type), .bus_req_id(bus_req_id),
    .bus_req_addr(bus_req_addr), .bus_req_data(bus_req_data),
    .bus_ack(bus_ack), .bus_rd_data(bus_rd_data),
    .snp_valid(snp_valid), .snp_type(snp_type), .snp_id(snp_id),
    .snp_addr(snp_addr), .snp_data(snp_data)
  );

  int n_chk = 0;
  int n_fail = 0;

  logic [DATA_W-1:0] mem [MEMSZ];
  logic              mv  [LINES];
  logic [TAG_W-1:0]  mt  [LINES];
  logic [DATA_W-1:0] md  [LINES];

  function automatic int b_idx(input logic [ADDR_W-1:0] a);
    return int'(a) % LINES;
  endfunction
  function automatic logic [TAG_W-1:0] b_tag(input logic [ADDR_W-1:0] a);
    return TAG_W'(int'(a) / LINES);
  endfunction
  function automatic bit b_hit(input logic [ADDR_W-1:0] a);
    return mv[b_idx(a)] && mt[b_idx(a)] == b_tag(a);
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, input logic [1:0] ctype,
                         input logic [DATA_W-1:0] cdata, input string rq);
    bit exp_hit = b_hit(a);
    logic [DATA_W-1:0] exp_data = mem[a];
    int cyc = 0;
    bit saw_bus = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = a;
    forever begin
      @(negedge clk);
      cyc++;
      if (cpu_ready) break;
      if (cyc > 40) begin
        chk(0, rq, "read timeout", 0, 1);
        break;
      end
      if (bus_req_valid) begin
        saw_bus = 1;
        chk(bus_req_type == 2'd1, "R3", "read bus type", 32'(bus_req_type), 1);
        chk(bus_req_addr == a, "R3", "read bus addr", 32'(bus_req_addr), 32'(a));
        bus_ack = 1; bus_rd_data = mem[a];
        if (ctype != 0) begin
          snp_valid = 1; snp_type = ctype; snp_id = 2; snp_addr = a; snp_data = cdata;
        end
      end
    end
    bus_ack = 0; snp_valid = 0; cpu_req = 0;
    chk(saw_bus == !exp_hit, exp_hit ? "R2" : "R3", "bus used on read", 32'(saw_bus), 32'(!exp_hit));
    chk(cyc == (exp_hit ? 1 : 2), rq, "read ready cycle", 32'(cyc), exp_hit ? 1 : 2);
    chk(cpu_rdata == exp_data, rq, "read data", cpu_rdata, exp_data);
    if (!exp_hit) begin
      mv[b_idx(a)] = 1; mt[b_idx(a)] = b_tag(a); md[b_idx(a)] = mem[a];
    end
    if (ctype == 2'd2 || ctype == 2'd3) begin
      mem[a] = cdata;
      if (ctype == 2'd2) md[b_idx(a)] = cdata;
      else               mv[b_idx(a)] = 0;
    end
    @(negedge clk);
    chk(!cpu_ready, "R12", "ready pulse width", 32'(cpu_ready), 0);
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                          input bit minv, input string rq);
    int cyc = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d; mode_inv = minv;
    forever begin
      @(negedge clk);
      cyc++;
      mode_inv = ~minv; // mode only matters at acceptance
      if (cpu_ready) break;
      if (cyc > 40) begin
        chk(0, rq, "write timeout", 0, 1);
        break;
      end
      if (bus_req_valid) begin
        chk(bus_req_type == (minv ? 2'd3 : 2'd2), "R5", "write bus type", 32'(bus_req_type), minv ? 3 : 2);
        chk(bus_req_addr == a && bus_req_data == d, "R4", "write bus data", bus_req_data, d);
        chk(bus_req_id == ID_W'(MY_ID), "R4", "write bus id", 32'(bus_req_id), MY_ID);
        bus_ack = 1;
      end
    end
    bus_ack = 0; cpu_req = 0;
    chk(cyc == 2, rq, "write ready cycle", 32'(cyc), 2);
    mem[a] = d;
    if (b_hit(a)) md[b_idx(a)] = d;
  endtask

  task automatic do_snoop(input logic [1:0] t, input logic [ID_W-1:0] id,
                          input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    snp_valid = 1; snp_type = t; snp_id = id; snp_addr = a; snp_data = d;
    @(negedge clk);
    snp_valid = 0;
    chk(!bus_req_valid && !cpu_ready, "R9", "snoop causes no traffic", 32'(bus_req_valid), 0);
    if (id != ID_W'(MY_ID) && (t == 2'd2 || t == 2'd3)) begin
      mem[a] = d;
      if (b_hit(a)) begin
        if (t == 2'd2) md[b_idx(a)] = d;
        else           mv[b_idx(a)] = 0;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < MEMSZ; i++) mem[i] = 32'(i) * 32'h9E37_79B1 + 32'h1234;
    for (int i = 0; i < LINES; i++) begin mv[i] = 0; mt[i] = '0; md[i] = '0; end
    repeat (3) @(negedge clk);
    chk(!cpu_ready && !bus_req_valid, "R1", "outputs in reset", 32'(cpu_ready), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!cpu_ready && !bus_req_valid, "R1", "outputs after reset", 32'(bus_req_valid), 0);

    do_read(12'h005, 0, 0, "R1");            // first access misses
    do_read(12'h005, 0, 0, "R2");            // hit
    do_write(12'h005, 32'hAAAA_0001, 0, "R6"); // write hit, update type
    do_read(12'h005, 0, 0, "R6");
    do_write(12'h105, 32'hBBBB_0002, 1, "R6"); // write miss, invalidate type
    do_read(12'h105, 0, 0, "R6");            // misses: no allocate
    do_read(12'h021, 0, 0, "R3");
    do_snoop(2'd2, 2, 12'h021, 32'hC0DE_0003); // R7 match
    do_read(12'h021, 0, 0, "R7");
    do_snoop(2'd2, 3, 12'h0A1, 32'hC0DE_0004); // R7 tag mismatch
    do_read(12'h021, 0, 0, "R7");
    do_snoop(2'd3, 0, 12'h021, 32'hC0DE_0005); // R8
    do_read(12'h021, 0, 0, "R8");
    do_snoop(2'd2, 2'(MY_ID), 12'h021, 32'hDEAD_0006); // R9 ignored
    do_read(12'h021, 0, 0, "R9");
    do_snoop(2'd3, 2'(MY_ID), 12'h021, 32'hDEAD_0007); // R9 ignored
    do_read(12'h021, 0, 0, "R9");
    do_snoop(2'd1, 2, 12'h021, 32'hDEAD_0008); // R10 ignored
    do_read(12'h021, 0, 0, "R10");
    do_read(12'h033, 2'd2, 32'hF111_0009, "R11"); // fill plus update snoop
    do_read(12'h033, 0, 0, "R11");
    do_read(12'h046, 2'd3, 32'hF222_000A, "R11"); // fill plus invalidate snoop
    do_read(12'h046, 0, 0, "R11");

    for (int n = 0; n < 400; n++) begin
      int op = int'($urandom_range(0, 9));
      logic [ADDR_W-1:0] a = ADDR_W'($urandom_range(0, 47));
      if (op < 4)      do_read(a, 0, 0, "R2");
      else if (op < 7) do_write(a, $urandom, 1'($urandom_range(0, 1)), "R4");
      else if (op < 8) do_read(a, b_hit(a) ? 2'd0 : 2'($urandom_range(2, 3)), $urandom, "R11");
      else             do_snoop(2'($urandom_range(1, 3)), 2'($urandom_range(0, 3)), a, $urandom);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule